// File: doc/BRIEF.md
# Multi-Channel General-Purpose Timer

This block is a register-mapped timer with six independent 32-bit channels. Each channel owns a control register, a clock-setup register, a read-only counter and a compare register. A channel counts divided ticks taken from one of two input strobe lines: a fast system strobe or a slow low-frequency strobe. It runs in one of three behaviours. In one-shot it stops at the compare value. In repeat it restarts from zero at the compare value. In free-run it keeps counting past the compare value.

Every compare match raises a per-channel pending flag. A global enable register decides which flags reach the single interrupt output. Software clears flags by writing ones to the acknowledge address, and reads the pending flags back at that same address. Writes take effect on the rising clock edge. Reads are combinational from the address.

Top module: `gpt_timer`

## Requirements
- R1: Global registers: interrupt enable at 0x00 and acknowledge/pending at 0x08. Channel N (1..6) has control at 0x10·N, clock setup at 0x10·N+0x4, counter at 0x10·N+0x8 and compare at 0x10·N+0xC. After reset every register reads 0. An address that maps to no register reads 0.
- R2: Control bit 0 is the channel enable, and bits 5:4 hold the mode: 0 one-shot, 1 repeat, 3 free-run, 2 behaves as free-run. Bit 1 is a clear strobe that reads back as 0. It zeroes the counter and the divider, and it wins over a tick in the same cycle; a tick suppressed this way raises no match.
- R3: In clock setup, bit 4 picks the strobe (0 = tick_sys, 1 = tick_slow), and bits 3:0 hold a code k. An enabled channel advances once every k+1 selected strobes. The unselected strobe has no effect.
- R4: The counter rises by exactly one per divided tick and otherwise holds. It is read-only, so a bus write to it leaves it unchanged.
- R5: A match occurs when the counter's incremented value equals compare. A match sets pending bit N-1 whatever the interrupt-enable register holds.
- R6: In repeat mode a match loads the counter with 0.
- R7: In one-shot mode a match leaves the counter at the compare value and clears the enable bit, so later ticks are ignored. Free-run keeps counting after a match.
- R8: Writing 0x08 clears each pending bit written as 1 and leaves bits written as 0 untouched. A match in the same cycle as its acknowledge leaves the bit set.
- R9: irq is high exactly when some pending bit has its interrupt-enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_sys | input | 1 | Fast time-base strobe, one cycle per tick |
| tick_slow | input | 1 | Slow time-base strobe, one cycle per tick |
| bus_we | input | 1 | Write strobe for bus_addr / bus_wdata |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The sharpest overlap is a compare match and a software acknowledge of the same pending bit landing on one edge. The bench provokes it with a repeat channel whose compare value is 1, so every strobe matches, and writes the acknowledge while the strobe is high. Reading the pending register afterwards must show the bit still set. A second write without the strobe must then clear it. A clear strobe written during a live tick is the other collision: the counter must read zero with no new flag. Random traffic is compared cycle by cycle against a bench model.

// File: rtl/gpt_pkg.sv
// Package: shared constants and types for the multi-channel timer.
// Assumes a 32-bit data path and word-aligned register offsets.
package gpt_pkg;
    localparam int DATA_W = 32;
    localparam int DIV_W  = 4;     // divider code sits below the source bit
    localparam int IDX_W  = 4;     // channel index nibble of the address
    localparam int SEL_W  = 2;     // register select inside one channel

    typedef enum logic [1:0] {
        MODE_ONCE   = 2'd0,
        MODE_REPEAT = 2'd1,
        MODE_SPARE  = 2'd2,
        MODE_FREE   = 2'd3
    } gpt_mode_e;

    // register select values inside a 16-byte window
    localparam logic [SEL_W-1:0] SEL_CTRL  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_SETUP = 2'd1;
    localparam logic [SEL_W-1:0] SEL_COUNT = 2'd2;
    localparam logic [SEL_W-1:0] SEL_CMP   = 2'd3;

    // control field positions
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;
    localparam int CTRL_MODE_LO = 4;
    localparam int SETUP_SRC_BIT = 4;
endpackage

// File: rtl/gpt_tick_div.sv
// Module: tick selection and divider for one channel.
// Picks one of two strobes and emits one tick every (code+1) strobes
// while running. Held at zero while stopped or on a restart request.
module gpt_tick_div #(
    parameter int DIVW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic            src_sel,
    input  logic [DIVW-1:0] div_code,
    input  logic            strobe_sys,
    input  logic            strobe_slow,
    output logic            tick_o
);
    logic            strobe;
    logic            at_end;
    logic [DIVW-1:0] div_cnt;

    // pick the strobe and decide whether this strobe closes a period
    always_comb begin
        strobe = src_sel ? strobe_slow : strobe_sys;
        at_end = (div_cnt == div_code);
        tick_o = run && strobe && at_end;
    end

    // divider position: reset when stopped, wrap at the end of a period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!run || restart) begin
            div_cnt <= '0;
        end else if (strobe) begin
            div_cnt <= at_end ? '0 : div_cnt + 1'b1;
        end
    end

    AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !restart) |=> (!tick_o || div_code == '0)); // R3

    AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |-> !tick_o); // R3
endmodule

// File: rtl/gpt_chan.sv
// Module: one timer channel with control, clock setup, counter, compare.
// Assumes writes are pre-decoded by the parent; match_o is a one-cycle
// pulse on the edge at which the counter reaches the compare value.
module gpt_chan
    import gpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              setup_we,
    input  logic              cmp_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick_sys,
    input  logic              tick_slow,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] setup_rd,
    output logic [DATA_W-1:0] cnt_o,
    output logic [DATA_W-1:0] cmp_o,
    output logic              match_o
);
    logic              en_q;
    gpt_mode_e         mode_q;
    logic              src_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cmp_q;
    logic              clr_req;
    logic              raw_tick;
    logic              tick;
    logic [DATA_W-1:0] cnt_inc;
    logic              hit;

    gpt_tick_div #(.DIVW(DIV_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (en_q),
        .restart    (clr_req),
        .src_sel    (src_q),
        .div_code   (div_q),
        .strobe_sys (tick_sys),
        .strobe_slow(tick_slow),
        .tick_o     (raw_tick)
    );

    // clear requests, effective tick and compare detection
    always_comb begin
        clr_req = ctrl_we && wdata[CTRL_CLR_BIT];
        tick    = raw_tick && !clr_req;
        cnt_inc = cnt_q + 1'b1;
        hit     = tick && (cnt_inc == cmp_q);
        match_o = hit;
    end

    // counter: clear wins, then restart or advance on a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_req) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (hit && mode_q == MODE_REPEAT) ? '0 : cnt_inc;
        end
    end

    // enable and mode: bus write first, one-shot stop on match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= MODE_ONCE;
        end else if (ctrl_we) begin
            en_q   <= wdata[CTRL_EN_BIT];
            mode_q <= gpt_mode_e'(wdata[CTRL_MODE_LO +: 2]);
        end else if (hit && mode_q == MODE_ONCE) begin
            en_q   <= 1'b0;
        end
    end

    // clock setup and compare value storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= 1'b0;
            div_q <= '0;
            cmp_q <= '0;
        end else begin
            if (setup_we) begin
                src_q <= wdata[SETUP_SRC_BIT];
                div_q <= wdata[DIV_W-1:0];
            end
            if (cmp_we) begin
                cmp_q <= wdata;
            end
        end
    end

    // read-back images; the clear bit always reads as zero
    always_comb begin
        ctrl_rd  = '0;
        ctrl_rd[CTRL_EN_BIT]         = en_q;
        ctrl_rd[CTRL_MODE_LO +: 2]   = mode_q;
        setup_rd = '0;
        setup_rd[SETUP_SRC_BIT]      = src_q;
        setup_rd[DIV_W-1:0]          = div_q;
        cnt_o    = cnt_q;
        cmp_o    = cmp_q;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (cnt_q == '0)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw_tick && !clr_req) |=> $stable(cnt_q)); // R4

    AST_REPEAT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode_q == MODE_REPEAT) |=> (cnt_q == '0)); // R6

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode_q == MODE_ONCE && !ctrl_we) |=> (!en_q && cnt_q == $past(cmp_q))); // R7
endmodule

// File: rtl/gpt_irq.sv
// Module: pending flags, interrupt enables and the combined interrupt.
// Assumes set_i pulses for one cycle per match; a set beats an acknowledge.
module gpt_irq #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_we,
    input  logic           ack_we,
    input  logic [NCH-1:0] wbits,
    input  logic [NCH-1:0] set_i,
    output logic [NCH-1:0] en_o,
    output logic [NCH-1:0] pend_o,
    output logic           irq_o
);
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] ack_bits;

    // acknowledge mask applies only on a write to the acknowledge address
    always_comb begin
        ack_bits = ack_we ? wbits : '0;
        en_o     = en_q;
        pend_o   = pend_q;
        irq_o    = |(pend_q & en_q);
    end

    // enable register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_we) begin
            en_q <= wbits;
        end
    end

    // pending flags: acknowledge clears, a new match sets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~ack_bits) | set_i;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i))); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_bits & ~set_i) != '0) |=> ((pend_q & $past(ack_bits & ~set_i)) == '0)); // R8

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(set_i != '0 || en_we)); // R9
endmodule

// File: rtl/gpt_timer.sv
// Module: top of the multi-channel timer; decodes the register window,
// instantiates the channels and the interrupt collector, muxes reads.
// Assumes word-aligned addresses; bus_addr[1:0] are ignored.
module gpt_timer
    import gpt_pkg::*;
#(
    parameter int NCH = 6,
    parameter int AW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_sys,
    input  logic              tick_slow,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam logic [SEL_W-1:0] SEL_IEN = 2'd0;
    localparam logic [SEL_W-1:0] SEL_ACK = 2'd2;

    logic [IDX_W-1:0] chan_idx;
    logic [SEL_W-1:0] reg_sel;
    logic             glob_hit;

    logic [DATA_W-1:0] ctrl_rd  [NCH];
    logic [DATA_W-1:0] setup_rd [NCH];
    logic [DATA_W-1:0] cnt_rd   [NCH];
    logic [DATA_W-1:0] cmp_rd   [NCH];
    logic [NCH-1:0]    match;
    logic [NCH-1:0]    ien;
    logic [NCH-1:0]    pend;

    // split the address into channel index and register select
    always_comb begin
        chan_idx = bus_addr[4 +: IDX_W];
        reg_sel  = bus_addr[2 +: SEL_W];
        glob_hit = (chan_idx == '0);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic sel_me;
        // this channel owns the current address window
        always_comb sel_me = (chan_idx == IDX_W'(g + 1));

        gpt_chan u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_we  (bus_we && sel_me && reg_sel == SEL_CTRL),
            .setup_we (bus_we && sel_me && reg_sel == SEL_SETUP),
            .cmp_we   (bus_we && sel_me && reg_sel == SEL_CMP),
            .wdata    (bus_wdata),
            .tick_sys (tick_sys),
            .tick_slow(tick_slow),
            .ctrl_rd  (ctrl_rd[g]),
            .setup_rd (setup_rd[g]),
            .cnt_o    (cnt_rd[g]),
            .cmp_o    (cmp_rd[g]),
            .match_o  (match[g])
        );
    end

    gpt_irq #(.NCH(NCH)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .en_we (bus_we && glob_hit && reg_sel == SEL_IEN),
        .ack_we(bus_we && glob_hit && reg_sel == SEL_ACK),
        .wbits (bus_wdata[NCH-1:0]),
        .set_i (match),
        .en_o  (ien),
        .pend_o(pend),
        .irq_o (irq)
    );

    // read multiplexer; unmapped locations return zero
    always_comb begin
        bus_rdata = '0;
        if (glob_hit) begin
            if (reg_sel == SEL_IEN) bus_rdata[NCH-1:0] = ien;
            else if (reg_sel == SEL_ACK) bus_rdata[NCH-1:0] = pend;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (chan_idx == IDX_W'(i + 1)) begin
                    case (reg_sel)
                        SEL_CTRL:  bus_rdata = ctrl_rd[i];
                        SEL_SETUP: bus_rdata = setup_rd[i];
                        SEL_COUNT: bus_rdata = cnt_rd[i];
                        default:   bus_rdata = cmp_rd[i];
                    endcase
                end
            end
        end
    end

    AST_MATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (match != '0) |=> ((pend & $past(match)) == $past(match))); // R5
endmodule

// File: tb/sim_gpt_timer.sv
module sim_gpt_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_sys = 1'b0;
    logic        tick_slow = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    logic [31:0] m_cnt [NCH];
    logic [31:0] m_cmp [NCH];
    logic        m_en  [NCH];
    logic [1:0]  m_mode[NCH];
    logic        m_src [NCH];
    logic [3:0]  m_div [NCH];
    logic [3:0]  m_dcnt[NCH];
    logic [5:0]  m_pend;
    logic [5:0]  m_ien;

    gpt_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_sys(tick_sys), .tick_slow(tick_slow),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // next state of the reference from the inputs about to be clocked
    task automatic model_step();
        logic [5:0] setv;
        logic [5:0] ackv;
        setv = '0;
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_cnt[i] = '0; m_cmp[i] = '0; m_en[i] = 1'b0; m_mode[i] = '0;
                m_src[i] = 1'b0; m_div[i] = '0; m_dcnt[i] = '0;
            end
            m_pend = '0; m_ien = '0;
            return;
        end
        for (int i = 0; i < NCH; i++) begin
            logic wch, cw, clr, sel, tk, hit;
            logic [31:0] nx;
            wch = bus_we && (bus_addr[7:4] == 4'(i + 1));
            cw  = wch && bus_addr[3:2] == 2'd0;
            clr = cw && bus_wdata[1];
            sel = m_src[i] ? tick_slow : tick_sys;
            tk  = m_en[i] && sel && (m_dcnt[i] == m_div[i]) && !clr;
            nx  = m_cnt[i] + 32'd1;
            hit = tk && (nx == m_cmp[i]);
            setv[i] = hit;
            if (!m_en[i] || clr) m_dcnt[i] = '0;
            else if (sel) m_dcnt[i] = (m_dcnt[i] == m_div[i]) ? 4'd0 : m_dcnt[i] + 4'd1;
            if (clr) m_cnt[i] = '0;
            else if (tk) m_cnt[i] = (hit && m_mode[i] == 2'd1) ? 32'd0 : nx;
            if (cw) begin
                m_en[i] = bus_wdata[0];
                m_mode[i] = bus_wdata[5:4];
            end else if (hit && m_mode[i] == 2'd0) begin
                m_en[i] = 1'b0;
            end
            if (wch && bus_addr[3:2] == 2'd1) begin
                m_src[i] = bus_wdata[4];
                m_div[i] = bus_wdata[3:0];
            end
            if (wch && bus_addr[3:2] == 2'd3) m_cmp[i] = bus_wdata;
        end
        ackv = (bus_we && bus_addr[7:2] == 6'd2) ? bus_wdata[5:0] : 6'd0;
        m_pend = (m_pend & ~ackv) | setv;
        if (bus_we && bus_addr[7:2] == 6'd0) m_ien = bus_wdata[5:0];
    endtask

    function automatic logic [31:0] model_read(logic [7:0] a);
        logic [31:0] r;
        int c;
        r = '0;
        c = int'(a[7:4]);
        if (c == 0) begin
            if (a[3:2] == 2'd0) r = {26'd0, m_ien};
            else if (a[3:2] == 2'd2) r = {26'd0, m_pend};
        end else if (c <= NCH) begin
            case (a[3:2])
                2'd0: r = {26'd0, m_mode[c-1], 3'd0, m_en[c-1]};
                2'd1: r = {27'd0, m_src[c-1], m_div[c-1]};
                2'd2: r = m_cnt[c-1];
                default: r = m_cmp[c-1];
            endcase
        end
        return r;
    endfunction

    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cycle();
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic ticks(logic s, logic l, int n);
        tick_sys = s; tick_slow = l;
        repeat (n) cycle();
        tick_sys = 1'b0; tick_slow = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) cycle();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();

        // R1: reset values and unmapped reads
        rd_chk(8'h00, 0, "R1 ien reset");
        rd_chk(8'h08, 0, "R1 pend reset");
        rd_chk(8'h10, 0, "R1 ctrl reset");
        rd_chk(8'h68, 0, "R1 cnt6 reset");
        chk("R1 irq reset", {31'd0, irq}, 0);

        // channel 1 repeat, compare 3, divide by 1 on tick_sys
        wr(8'h1C, 3);
        wr(8'h14, 0);
        wr(8'h10, 32'h13);
        ticks(1, 0, 2);
        rd_chk(8'h18, 2, "R4 count two ticks");
        ticks(1, 0, 1);
        rd_chk(8'h18, 0, "R6 repeat restart");
        rd_chk(8'h08, 1, "R5 pend bit0");
        rd_chk(8'h10, 32'h11, "R2 clear reads zero");
        wr(8'h18, 32'h55);
        rd_chk(8'h18, 0, "R4 counter write ignored");
        ticks(1, 0, 2);
        rd_chk(8'h18, 2, "R4 count again");
        wr(8'h08, 1);
        rd_chk(8'h08, 0, "R8 ack clears");
        tick_sys = 1'b1;
        wr(8'h10, 32'h13);
        tick_sys = 1'b0;
        rd_chk(8'h18, 0, "R2 clear beats tick");
        rd_chk(8'h08, 0, "R2 no match on cleared tick");
        wr(8'h10, 32'h10);

        // channel 3 one-shot, compare 2
        wr(8'h3C, 2);
        wr(8'h30, 32'h03);
        ticks(1, 0, 5);
        rd_chk(8'h30, 0, "R7 one-shot disables");
        rd_chk(8'h38, 2, "R7 one-shot holds compare");
        rd_chk(8'h08, 4, "R5 pend bit2");

        // channel 2 free-run on tick_slow divide by 3
        wr(8'h24, 32'h12);
        wr(8'h2C, 100);
        wr(8'h20, 32'h33);
        ticks(1, 0, 5);
        rd_chk(8'h28, 0, "R3 other strobe ignored");
        rd_chk(8'h20, 32'h31, "R2 free-run ctrl");
        ticks(0, 1, 6);
        rd_chk(8'h28, 2, "R3 divide by three");
        wr(8'h2C, 5);
        ticks(0, 1, 9);
        rd_chk(8'h28, 5, "R5 free-run at compare");
        ticks(0, 1, 3);
        rd_chk(8'h28, 6, "R7 free-run continues");
        rd_chk(8'h08, 6, "R5 pend bit1");

        // channel 4 spare mode acts as free-run
        wr(8'h4C, 1);
        wr(8'h40, 32'h23);
        ticks(1, 0, 3);
        rd_chk(8'h48, 3, "R2 spare mode keeps counting");
        rd_chk(8'h40, 32'h21, "R2 spare mode stays enabled");
        rd_chk(8'h08, 32'hE, "R5 pend bit3");

        // R9 interrupt gating
        chk("R9 masked irq", {31'd0, irq}, 0);
        wr(8'h00, 4);
        rd_chk(8'h00, 4, "R1 ien readback");
        chk("R9 enabled irq", {31'd0, irq}, 1);
        wr(8'h08, 4);
        rd_chk(8'h08, 32'hA, "R8 only written bit cleared");
        chk("R9 irq drops", {31'd0, irq}, 0);

        // R8 acknowledge and match in the same cycle
        wr(8'h5C, 1);
        wr(8'h50, 32'h13);
        ticks(1, 0, 1);
        rd_chk(8'h08, 32'h1A, "R5 pend bit4");
        tick_sys = 1'b1;
        wr(8'h08, 32'h10);
        tick_sys = 1'b0;
        rd_chk(8'h08, 32'h1A, "R8 set beats ack");
        wr(8'h08, 32'h10);
        rd_chk(8'h08, 32'h0A, "R8 ack without match");

        rd_chk(8'h04, 0, "R1 unmapped 0x04");
        rd_chk(8'h0C, 0, "R1 unmapped 0x0C");
        rd_chk(8'h70, 0, "R1 unmapped 0x70");

        // random traffic against the reference (R1..R9)
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            int r;
            tick_sys  = 1'($urandom % 2);
            tick_slow = ($urandom % 4) == 0;
            r = $urandom % 16;
            if (r < 4) begin
                logic [7:0] a;
                logic [31:0] d;
                if (($urandom % 10) == 0) begin
                    a = (($urandom % 2) == 0) ? 8'h00 : 8'h08;
                    d = $urandom % 64;
                end else begin
                    a = {4'(1 + $urandom % NCH), 2'($urandom % 4), 2'd0};
                    case (a[3:2])
                        2'd1: d = $urandom & 32'h13;
                        2'd3: d = $urandom % 24;
                        default: d = $urandom;
                    endcase
                end
                bus_we = 1'b1; bus_addr = a; bus_wdata = d;
            end
            cycle();
            bus_we = 1'b0; bus_wdata = '0;
            begin
                logic [7:0] ra;
                ra = {4'($urandom % 8), 2'($urandom % 4), 2'd0};
                rd_chk(ra, model_read(ra), "R1-map random read");
                chk("R9 random irq", {31'd0, irq}, {31'd0, |(m_pend & m_ien)});
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule